// File: doc/BRIEF.md
# Interlocked Read Handshake Controller

This block carries read transfers between one requesting master and a set of memory-mapped responders over a shared bus. No clock period governs the transfer. Each step waits for the other party's ready line to change, so the sequence forms a full four-phase interlock. The block is built as synchronous logic, and every phase takes at least one clock. A slow responder therefore stretches the transfer without either side depending on a fixed delay.

A local request (`start_i` with `addr_i`) opens a transfer. The master first puts the address and the read qualifier on the bus. One cycle later it raises its ready line. Every responder compares the address against its own window, and only the owner of that window answers. That responder waits out its configured latency, puts its word on the data lines and raises its own ready line. The master takes the word in the cycle it sees that ready line high. It then drops its ready line and withdraws the address. The responder releases its lines after it sees master-ready fall, and the master retires the transfer once responder-ready is low again.

Top module: `rd_handshake`

## Requirements
- R1: While `rst_n` is low, `bus_mrdy_o`, `bus_srdy_o`, `busy_o`, `done_o` and `bus_rd_o` are 0, and `bus_addr_o` and `bus_data_o` are all zeros.
- R2: The address and `bus_rd_o` appear on the bus one cycle before `bus_mrdy_o` rises. They stay unchanged for as long as `bus_mrdy_o` is high and `bus_srdy_o` is low.
- R3: A responder answers only when bits [AW-1:OFF_W] of the bus address equal the same bits of its base. At most one responder drives ready at a time. A responder that is not addressed leaves the data lines at zero.
- R4: The master captures `bus_data_o` into `rd_data_o` in the cycle it sees `bus_srdy_o` high. In the next cycle it lowers `bus_mrdy_o` and returns `bus_addr_o` and `bus_rd_o` to zero.
- R5: A responder holds ready and its data steady while `bus_mrdy_o` is high. It drops both in the cycle after it sees `bus_mrdy_o` low.
- R6: A new request is accepted only from the idle state, which the master reaches only after it sees `bus_srdy_o` low. A `start_i` pulse that arrives while `busy_o` is high is ignored.
- R7: `done_o` is high in the cycle that follows the (6 + latency)-th rising edge after the edge that samples `start_i`. The default latencies are 2 for the responder at base 0x10 and 5 for the responder at base 0x40.
- R8: `done_o` is a single-cycle pulse. `rd_data_o` keeps the last captured word until the next capture.
- R9: `bus_srdy_o` never rises while `bus_mrdy_o` is low, and `bus_mrdy_o` never rises while `bus_srdy_o` is high.
- R10: The word a responder returns is its key plus the zero-extended address. With the defaults, the responder at base 0x10 has key 0xA000 and the responder at base 0x40 has key 0xB000, and both windows are 16 addresses wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to open a read transfer |
| addr_i | input | AW | Address of the requested word |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse when a transfer retires |
| rd_data_o | output | DW | Last word captured by the master |
| bus_addr_o | output | AW | Bus address lines |
| bus_rd_o | output | 1 | Bus read qualifier |
| bus_mrdy_o | output | 1 | Master-ready line |
| bus_srdy_o | output | 1 | Combined responder-ready line |
| bus_data_o | output | DW | Combined responder data lines |

## Verification
Two events can land in the same cycle: the master retiring one transfer, which raises `done_o` and returns it to idle, and a fresh request being sampled. The table walk provokes this by raising `start_i` in the very cycle `done_o` is seen. The check is that each following transfer returns its own responder's word with exactly its own latency. A request issued while a transfer is in flight is a second kind of overlap. That case is judged by the returned word, by the transfer count and by `busy_o` staying low afterwards. A negedge monitor confirms that no ready line rises out of phase and that the address holds steady under master-ready.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    M_IDLE    = 2'd0,
    M_DRIVE   = 2'd1,
    M_WAIT    = 2'd2,
    M_RELEASE = 2'd3
  } m_state_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BUSY = 2'd1,
    S_ACK  = 2'd2
  } s_state_t;
endpackage

// File: rtl/hs_master.sv
module hs_master #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          srdy_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          mrdy_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o
);
  import hs_pkg::*;

  m_state_t      state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata_q;
  logic          done_q, done_d;
  logic          addr_en, data_en;

  always_comb begin
    state_d = state_q;
    addr_en = 1'b0;
    data_en = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      M_IDLE:    if (start_i) begin addr_en = 1'b1; state_d = M_DRIVE; end
      M_DRIVE:   state_d = M_WAIT;
      M_WAIT:    if (srdy_i) begin data_en = 1'b1; state_d = M_RELEASE; end
      M_RELEASE: if (!srdy_i) begin done_d = 1'b1; state_d = M_IDLE; end
      default:   state_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      addr_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (addr_en) addr_q  <= addr_i;
      if (data_en) rdata_q <= data_i;
    end
  end

  logic drive_bus;
  assign drive_bus = (state_q == M_DRIVE) || (state_q == M_WAIT);
  assign addr_o    = drive_bus ? addr_q : '0;
  assign rd_o      = drive_bus;
  assign mrdy_o    = (state_q == M_WAIT);
  assign busy_o    = (state_q != M_IDLE);
  assign done_o    = done_q;
  assign rd_data_o = rdata_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mrdy_o && !srdy_i) |=> ($stable(addr_o) && rd_o)); // R2
  AST_ADDR_BEFORE_MRDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mrdy_o) |-> ($stable(addr_o) && $past(rd_o))); // R2
  AST_MRDY_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mrdy_o) |-> !srdy_i); // R9
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (mrdy_o && srdy_i) |=> (!mrdy_o && !rd_o && addr_o == '0)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
endmodule

// File: rtl/hs_slave.sv
module hs_slave #(
  parameter int            AW    = 8,
  parameter int            DW    = 16,
  parameter int            OFF_W = 4,
  parameter logic [AW-1:0] BASE  = '0,
  parameter int            LAT   = 1,
  parameter logic [DW-1:0] KEY   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          mrdy_i,
  output logic          srdy_o,
  output logic [DW-1:0] data_o
);
  import hs_pkg::*;

  localparam int CW = (LAT < 1) ? 1 : $clog2(LAT + 1);

  s_state_t      state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] data_q;
  logic          hit, load_en;

  assign hit = rd_i && (addr_i[AW-1:OFF_W] == BASE[AW-1:OFF_W]);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    case (state_q)
      S_IDLE: if (mrdy_i && hit) begin
        load_en = 1'b1;
        cnt_d   = CW'(LAT);
        state_d = S_BUSY;
      end
      S_BUSY: if (cnt_q == '0) state_d = S_ACK;
              else             cnt_d   = cnt_q - 1'b1;
      S_ACK:  if (!mrdy_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (load_en) data_q <= KEY + DW'(addr_i);
    end
  end

  assign srdy_o = (state_q == S_ACK);
  assign data_o = srdy_o ? data_q : '0;

  AST_SRDY_AFTER_MRDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srdy_o) |-> mrdy_i); // R9
  AST_SRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (srdy_o && mrdy_i) |=> (srdy_o && $stable(data_o))); // R5
  AST_SRDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (srdy_o && !mrdy_i) |=> (!srdy_o && data_o == '0)); // R5
endmodule

// File: rtl/rd_handshake.sv
module rd_handshake #(
  parameter int                   AW       = 8,
  parameter int                   DW       = 16,
  parameter int                   OFF_W    = 4,
  parameter int                   NSLV     = 2,
  parameter logic [NSLV*AW-1:0]   SLV_BASE = {8'h40, 8'h10},
  parameter logic [NSLV*8-1:0]    SLV_LAT  = {8'd5, 8'd2},
  parameter logic [NSLV*DW-1:0]   SLV_KEY  = {16'hB000, 16'hA000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rd_o,
  output logic          bus_mrdy_o,
  output logic          bus_srdy_o,
  output logic [DW-1:0] bus_data_o
);
  logic [NSLV-1:0] srdy_v;
  logic [DW-1:0]   data_v [NSLV];

  hs_master #(.AW(AW), .DW(DW)) u_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .srdy_i(bus_srdy_o), .data_i(bus_data_o),
    .addr_o(bus_addr_o), .rd_o(bus_rd_o), .mrdy_o(bus_mrdy_o),
    .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o)
  );

  for (genvar i = 0; i < NSLV; i++) begin : g_slv
    hs_slave #(
      .AW(AW), .DW(DW), .OFF_W(OFF_W),
      .BASE(SLV_BASE[i*AW +: AW]),
      .LAT(int'(SLV_LAT[i*8 +: 8])),
      .KEY(SLV_KEY[i*DW +: DW])
    ) u_slv (
      .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_o), .rd_i(bus_rd_o),
      .mrdy_i(bus_mrdy_o), .srdy_o(srdy_v[i]), .data_o(data_v[i])
    );
  end

  always_comb begin
    bus_data_o = '0;
    for (int i = 0; i < NSLV; i++) bus_data_o = bus_data_o | data_v[i];
  end
  assign bus_srdy_o = |srdy_v;

  AST_ONE_RESPONDER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(srdy_v)); // R3
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_srdy_o |-> (bus_data_o == '0)); // R3
endmodule

// File: tb/sim_rd_handshake.sv
module sim_rd_handshake;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          busy_o, done_o, bus_rd_o, bus_mrdy_o, bus_srdy_o;
  logic [DW-1:0] rd_data_o, bus_data_o;
  logic [AW-1:0] bus_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  int viol_phase = 0;
  int viol_addr  = 0;

  always #2.5 clk = ~clk;

  rd_handshake u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o),
    .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o), .bus_mrdy_o(bus_mrdy_o),
    .bus_srdy_o(bus_srdy_o), .bus_data_o(bus_data_o)
  );

  localparam logic [AW-1:0] T_ADDR [NV] = '{8'h10, 8'h4F, 8'h1F, 8'h40, 8'h13, 8'h4A};
  localparam logic [DW-1:0] T_DATA [NV] = '{16'hA010, 16'hB04F, 16'hA01F, 16'hB040, 16'hA013, 16'hB04A};
  localparam int            T_CYC  [NV] = '{8, 11, 8, 11, 8, 11};

  // Phase monitor (R9) and address stability monitor (R2)
  logic          p_m, p_s;
  logic [AW-1:0] p_a;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_m <= 1'b0; p_s <= 1'b0; p_a <= '0;
    end else begin
      if (!p_s && bus_srdy_o && !bus_mrdy_o) viol_phase++;
      if (!p_m && bus_mrdy_o && bus_srdy_o)  viol_phase++;
      if (!p_m && bus_mrdy_o && (p_a != bus_addr_o || !bus_rd_o)) viol_addr++;
      if (p_m && bus_mrdy_o && !p_s && p_a != bus_addr_o) viol_addr++;
      if (p_s && !bus_mrdy_o && bus_addr_o != '0) viol_addr++;
      p_m <= bus_mrdy_o; p_s <= bus_srdy_o; p_a <= bus_addr_o;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge where done_o is seen
  task automatic do_read(input logic [AW-1:0] a, output int cyc);
    start_i = 1'b1; addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bus_mrdy_o && !bus_srdy_o && !busy_o && !done_o && !bus_rd_o, "R1 ready/flags", 
        {bus_mrdy_o, bus_srdy_o, busy_o, done_o, bus_rd_o}, 0);
    chk(bus_addr_o == '0 && bus_data_o == '0, "R1 bus lines", {bus_addr_o, bus_data_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk, each request raised in the done cycle of the previous one
    for (int i = 0; i < NV; i++) begin
      do_read(T_ADDR[i], cyc);
      chk(rd_data_o == T_DATA[i], "R10/R3 read word", rd_data_o, T_DATA[i]);
      chk(cyc == T_CYC[i], "R7 latency", cyc, T_CYC[i]);
    end

    // R8: hold of data and single-cycle done
    @(negedge clk);
    chk(!done_o, "R8 done single cycle", done_o, 0);
    repeat (3) @(negedge clk);
    chk(rd_data_o == 16'hB04A, "R8 data held", rd_data_o, 16'hB04A);

    // R6: request during a transfer is ignored
    start_i = 1'b1; addr_i = 8'h13;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    repeat (3) begin @(negedge clk); cyc++; end
    start_i = 1'b1; addr_i = 8'h45;
    repeat (2) begin @(negedge clk); cyc++; end
    start_i = 1'b0;
    while (!done_o && cyc < 200) begin @(negedge clk); cyc++; end
    chk(rd_data_o == 16'hA013, "R6 ignored start word", rd_data_o, 16'hA013);
    chk(cyc == 8, "R6 ignored start latency", cyc, 8);
    repeat (3) @(negedge clk);
    chk(!busy_o && !bus_mrdy_o, "R6 no second transfer", busy_o, 0);
    chk(rd_data_o == 16'hA013, "R8 data held after idle", rd_data_o, 16'hA013);

    // R1: reset during a transfer
    start_i = 1'b1; addr_i = 8'h40;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(bus_mrdy_o && busy_o, "R2 mid-transfer master-ready", bus_mrdy_o, 1);
    rst_n = 1'b0;
    #1;
    chk(!bus_mrdy_o && !bus_srdy_o && !busy_o && bus_addr_o == '0, "R1 async reset",
        {bus_mrdy_o, bus_srdy_o, busy_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(8'h4C, cyc);
    chk(rd_data_o == 16'hB04C, "R3 read after reset", rd_data_o, 16'hB04C);
    chk(cyc == 11, "R7 latency after reset", cyc, 11);

    chk(viol_phase == 0, "R9 phase order", viol_phase, 0);
    chk(viol_addr == 0, "R2/R4 address hold and withdraw", viol_addr, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule